// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This unit watches the hot-plug-detect line of a display transmitter port. The raw line is asynchronous and prone to contact bounce. It passes through a synchronizer and then a filter with two programmable settings: a sampling prescaler, and a count of consecutive disagreeing samples. The filter produces a clean connection level. Each change of that level is recorded as a sticky event: connection has one status bit and disconnection has another.

A third status bit collects the interrupt line of an attached transmitter core. All three bits follow the same scheme. Software clears a bit by writing a one to it, and enables it onto the single interrupt output through an active-high enable register. A small register port gives write access and registered read access to the filter settings, the status, the enables and the filtered level.

Top module: `hpd_irq_unit`

## Requirements
- R1: The level register (address 4) reads 1 while the filtered connection level is asserted and 0 otherwise. The filtered level is 0 after reset.
- R2: The filter word (address 0) holds a prescaler P in bits 15:12 and a count N in bits 7:0. The synchronized input is sampled every P+1 clocks. The level changes after N consecutive samples that disagree with it, and N=0 acts as N=1. With P=0, an input change driven before clock edge 0 updates the level at edge N+1.
- R3: An input pulse shorter than the required run of samples leaves the level unchanged and sets no status bit. A pulse exactly N samples long with P=0 is accepted.
- R4: A rise of the filtered level sets status bit 1, and a fall sets status bit 2. Both bits are sticky.
- R5: A high core interrupt input sets status bit 0, which is sticky.
- R6: A write to address 2 clears every status bit written as one. Bits written as zero keep their value. Address 2 reads as zero.
- R7: When a clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R8: The enable register (address 3, bits 2:0) is active-high. The interrupt output is the OR of status AND enable, registered one clock after the status.
- R9: After reset the status is 0, the enables are 0, the interrupt is low, and the filter word reads 0x0000A0A0.
- R10: A read strobe at a clock edge returns the addressed register on the read data bus with the valid flag high in the following cycle. The status is at address 1, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hpd_i | input | 1 | Raw asynchronous hot-plug-detect line |
| core_irq_i | input | 1 | Interrupt line of the attached core, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that the core interrupt input and the register port are synchronous to the clock and never change near a rising edge. Only the hot-plug line is asynchronous. The bench drives every input at the falling edge. It holds the hot-plug line steady for whole clock periods, so the synchronizer sees clean values and every filter outcome follows from a count of whole cycles. Filter settings change only while the line and the level agree, so no sample run is in progress across a reconfiguration.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int PRE_W   = 4;
  localparam int PRE_LSB = 12;
  localparam int CNT_W   = 8;
  localparam int NUM_SRC = 3;

  localparam int SRC_CORE = 0;
  localparam int SRC_RISE = 1;
  localparam int SRC_FALL = 2;

  localparam logic [PRE_W-1:0] RST_PRE = 4'hA;
  localparam logic [CNT_W-1:0] RST_CNT = 8'hA0;

  typedef enum logic [ADDR_W-1:0] {
    A_FILT = 3'd0,
    A_STAT = 3'd1,
    A_CLR  = 3'd2,
    A_MASK = 3'd3,
    A_LVL  = 3'd4
  } reg_addr_e;

  // Run length actually required; zero behaves as one.
  function automatic logic [CNT_W-1:0] run_needed(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  // True when one more disagreeing sample completes the run.
  function automatic logic run_done(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] n);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, run_needed(n)};
  endfunction
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce
  import hpd_irq_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [PW-1:0] pre_i,
  input  logic [CW-1:0] need_i,
  output logic          level_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [PW-1:0] pcnt;
  logic [CW-1:0] run;
  logic          tick;
  logic          differ;
  logic          flip;

  assign tick   = (pcnt >= pre_i);
  assign differ = (sample_i != level_o);
  assign flip   = tick && differ && run_done(CNT_W'(run), CNT_W'(need_i));
  assign rise_o = flip &&  sample_i;
  assign fall_o = flip && !sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt <= '0;
    else if (tick) pcnt <= '0;
    else pcnt <= pcnt + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run     <= '0;
      level_o <= 1'b0;
    end else if (tick) begin
      if (!differ) begin
        run <= '0;
      end else if (flip) begin
        run     <= '0;
        level_o <= sample_i;
      end else begin
        run <= run + CW'(1);
      end
    end
  end

  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(level_o));
  assert_single_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
  assert_rise_raises_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> level_o);
  assert_fall_drops_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !level_o);
  assert_level_moves_on_edge_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o || fall_o) |=> $stable(level_o));
endmodule

// File: rtl/hpd_irq_regs.sv
module hpd_irq_regs
  import hpd_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NS = NUM_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NS-1:0] events_i,
  input  logic          level_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] need_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          irq_o
);
  logic [NS-1:0] status;
  logic [NS-1:0] mask;
  logic [NS-1:0] clr_vec;
  logic [DW-1:0] rd_mux;
  logic          wr_filt, wr_clr, wr_mask;
  wire           unused_wdata = ^{wdata_i[DW-1:PRE_LSB+PRE_W], wdata_i[PRE_LSB-1:CNT_W]};

  assign wr_filt = wr_en_i && (addr_i == AW'(A_FILT));
  assign wr_clr  = wr_en_i && (addr_i == AW'(A_CLR));
  assign wr_mask = wr_en_i && (addr_i == AW'(A_MASK));
  assign clr_vec = wr_clr ? wdata_i[NS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_o  <= RST_PRE;
      need_o <= RST_CNT;
    end else if (wr_filt) begin
      pre_o  <= wdata_i[PRE_LSB +: PRE_W];
      need_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status <= '0;
    else         status <= (status & ~clr_vec) | events_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask <= '0;
    else if (wr_mask) mask <= wdata_i[NS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status & mask);
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(A_FILT): begin
        rd_mux[PRE_LSB +: PRE_W] = pre_o;
        rd_mux[CNT_W-1:0]        = need_o;
      end
      AW'(A_STAT): rd_mux[NS-1:0] = status;
      AW'(A_MASK): rd_mux[NS-1:0] = mask;
      AW'(A_LVL):  rd_mux[0]      = level_i;
      default:     rd_mux         = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));
  assert_event_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|events_i) |=> ((status & $past(events_i)) == $past(events_i)));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((status & $past(clr_vec & ~events_i)) == '0));
  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & mask) == '0) |=> !irq_o);
  assert_irq_raised_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status & mask)) |=> irq_o);
  assert_rvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hpd_i,
  input  logic              core_irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic               hpd_sampled;
  logic               hpd_level;
  logic               hpd_rise;
  logic               hpd_fall;
  logic [PRE_W-1:0]   cfg_pre;
  logic [CNT_W-1:0]   cfg_need;
  logic [NUM_SRC-1:0] src_events;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hpd_i),
    .q_o   (hpd_sampled)
  );

  hpd_debounce #(.PW(PRE_W), .CW(CNT_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(hpd_sampled),
    .pre_i   (cfg_pre),
    .need_i  (cfg_need),
    .level_o (hpd_level),
    .rise_o  (hpd_rise),
    .fall_o  (hpd_fall)
  );

  always_comb begin
    src_events           = '0;
    src_events[SRC_CORE] = core_irq_i;
    src_events[SRC_RISE] = hpd_rise;
    src_events[SRC_FALL] = hpd_fall;
  end

  hpd_irq_regs #(.DW(DATA_W), .AW(ADDR_W), .NS(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .events_i(src_events),
    .level_i (hpd_level),
    .pre_o   (cfg_pre),
    .need_o  (cfg_need),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/sim_hpd_irq_unit.sv
module sim_hpd_irq_unit;
  localparam time CLK_PERIOD = 10;
  localparam logic [2:0] FILT = 3'd0, STAT = 3'd1, CLR = 3'd2, MASK = 3'd3, LVL = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, hpd = 1'b0, core = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr  = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .hpd_i(hpd), .core_irq_i(core),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected read data", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check("R9 irq during reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    wait_n(1);
    rd(FILT, 32'h0000A0A0, "R9 filter reset word");
    rd(STAT, 32'h0, "R9 status reset");
    rd(MASK, 32'h0, "R9 enable reset");
    rd(LVL,  32'h0, "R1 level reset");
    check("R9 irq after reset", {31'b0, irq}, 32'h0);

    // P=0, N=3; enable rise and fall
    wr(FILT, 32'h0000_0003);
    wr(MASK, 32'h6);

    // R2 exact timing: level changes at edge N+1 = 4
    hpd = 1'b1;
    wait_n(4);
    rd(LVL, 32'h0, "R2 level still low at edge 4");
    rd(LVL, 32'h1, "R1 R2 level high after edge 4");
    check("R8 irq one cycle after rise status", {31'b0, irq}, 32'h1);
    rd(STAT, 32'h2, "R4 rise sets bit 1");
    wr(CLR, 32'h2);
    rd(STAT, 32'h0, "R6 rise bit cleared");
    check("R8 irq low after clear", {31'b0, irq}, 32'h0);

    // R3 short low glitch of 2 cycles rejected
    hpd = 1'b0; wait_n(2); hpd = 1'b1;
    wait_n(10);
    rd(LVL,  32'h1, "R3 level kept after short glitch");
    rd(STAT, 32'h0, "R3 no event from short glitch");

    // R4 fall
    hpd = 1'b0;
    wait_n(12);
    rd(LVL,  32'h0, "R1 level low after fall");
    rd(STAT, 32'h4, "R4 fall sets bit 2");
    check("R8 irq from fall", {31'b0, irq}, 32'h1);
    wr(CLR, 32'h4);

    // R3 boundary: pulse of exactly N cycles accepted
    hpd = 1'b1; wait_n(3); hpd = 1'b0;
    wait_n(12);
    rd(STAT, 32'h6, "R3 N-cycle pulse gives rise and fall");
    rd(LVL,  32'h0, "R3 level back low");

    // R6 zeros keep bits
    wr(CLR, 32'h1);
    rd(STAT, 32'h6, "R6 zero-written bits unchanged");
    wr(CLR, 32'h6);
    rd(STAT, 32'h0, "R6 ones clear");
    check("R8 irq low after full clear", {31'b0, irq}, 32'h0);

    // R5 core interrupt, masked off
    core = 1'b1; wait_n(1); core = 1'b0;
    wait_n(2);
    check("R8 masked core source keeps irq low", {31'b0, irq}, 32'h0);
    rd(STAT, 32'h1, "R5 core sets bit 0");
    wr(MASK, 32'h7);
    wait_n(1);
    check("R8 enabling core source raises irq", {31'b0, irq}, 32'h1);
    rd(MASK, 32'h7, "R10 enable readback");

    // R7 event beats clear in the same cycle
    core = 1'b1; wr_en = 1'b1; addr = CLR; wdata = 32'h1;
    @(negedge clk);
    core = 1'b0; wr_en = 1'b0;
    rd(STAT, 32'h1, "R7 core event wins over clear");
    wr(CLR, 32'h1);
    rd(STAT, 32'h0, "R6 core bit cleared");
    wait_n(1);
    check("R8 irq low with empty status", {31'b0, irq}, 32'h0);

    // R2 prescaler: P=3, N=2
    wr(FILT, 32'h0000_3002);
    rd(FILT, 32'h0000_3002, "R10 filter readback");
    hpd = 1'b1; wait_n(3); hpd = 1'b0;
    wait_n(20);
    rd(LVL,  32'h0, "R3 3-cycle pulse rejected with prescale");
    rd(STAT, 32'h0, "R3 no event with prescale");
    hpd = 1'b1;
    wait_n(4);
    rd(LVL, 32'h0, "R2 prescaled filter not yet changed");
    wait_n(12);
    rd(LVL,  32'h1, "R2 prescaled filter changed");
    rd(STAT, 32'h2, "R4 rise with prescale");
    wr(CLR, 32'h7);

    // R2 N=0 acts as 1
    wr(FILT, 32'h0);
    hpd = 1'b0;
    wait_n(2);
    rd(LVL, 32'h1, "R2 N=0 level before edge 2 update");
    rd(LVL, 32'h0, "R2 N=0 level after edge 2");
    rd(STAT, 32'h4, "R4 fall with N=0");

    // R10 map
    rd(CLR,  32'h0, "R6 clear address reads zero");
    rd(3'd7, 32'h0, "R10 unmapped address reads zero");

    wait_n(2);
    if (exp_q.size() != 0) check("R10 reads left unanswered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule